// File: doc/BRIEF.md
# Oscillator Enable and Ready Controller

This block is the digital side of two clock sources: a high-speed external source (a crystal, or an external clock fed in directly when bypass is selected) and an internal RC source. Software turns each source on with an enable bit in a small register file. A per-source counter then waits a programmable number of source-clock edges before it declares the source stable. Only after that is a glitch-free gated copy of the source clock released to the rest of the chip.

Each ready flag is brought into the register clock domain through two flops. The flag drops at once when its enable bit is cleared. A rising ready flag sets a sticky pending bit, and the pending bit raises the interrupt line when its enable bit is set. The internal source is also offered divided by two, for use as a PLL reference. The block exposes two analog-facing fields. One is a fixed 8-bit calibration value that software can read but not write. The other is a 5-bit trim field that software can change.

Top module: `oscen_ctrl`

## Requirements
- R1: After reset, address 0 (CTRL) reads with external enable [0]=0, internal enable [2]=1, bypass [4]=0, trim [12:8]=5'b10000 and calibration [23:16]=CAL_VAL. Address 1 (IRQ) reads 0 and irq is low.
- R2: The bypass bit CTRL[4] accepts a write only while the external enable is 0; writes made while the source is enabled leave it unchanged. With bypass set, the external source is byp_clk_i counted for BYP_STAB edges. With bypass clear, it is xtal_clk_i counted for XTAL_STAB edges.
- R3: A source's ready flag (ext_ready_o / CTRL[1], int_ready_o / CTRL[3]) never reads 1 before its source has made its limit of edges since enable. It reads 1 no later than 4 register cycles after the source has made limit+3 edges while enabled.
- R4: A ready flag reads 0 whenever its enable bit reads 0, starting in the same cycle in which the enable bit clears.
- R5: A gated clock output (ext_clk_o, int_clk_o) has no rising edge while its source is enabled but has made fewer than its limit of edges. It toggles once the source is ready, and it is quiet a few source cycles after the source is disabled.
- R6: The calibration field CTRL[23:16] and cal_o hold CAL_VAL; writes to the field have no effect.
- R7: The trim field CTRL[12:8] is read-write and drives trim_o.
- R8: While the internal source is ready, int_div2_o has one rising edge for every two rising edges of int_clk_o.
- R9: Pending bits IRQ[8] (external) and IRQ[9] (internal) read 1 from one register cycle after the matching ready flag rises, and stay set until a 1 is written to IRQ[16] or IRQ[17]. If a set and a clear happen in the same cycle, the set wins. The clear bits read 0.
- R10: irq equals the OR over both sources of pending AND interrupt enable, where IRQ[0] enables the external source and IRQ[1] the internal one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | register clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 1 | register select: 0 CTRL, 1 IRQ |
| wdata | input | 32 | write data |
| rdata | output | 32 | read data for addr, combinational |
| irq | output | 1 | ready interrupt |
| xtal_clk_i | input | 1 | crystal oscillator activity |
| byp_clk_i | input | 1 | externally driven clock for bypass mode |
| int_osc_i | input | 1 | internal RC oscillator activity |
| ext_clk_o | output | 1 | gated external clock |
| int_clk_o | output | 1 | gated internal clock |
| int_div2_o | output | 1 | internal clock divided by two |
| ext_ready_o | output | 1 | external ready flag, register domain |
| int_ready_o | output | 1 | internal ready flag, register domain |
| trim_o | output | 5 | trim value to the internal oscillator |
| cal_o | output | 8 | calibration value to the internal oscillator |

## Verification
A wrong enable, bypass or trim register shows up in the next register cycle as a rdata mismatch against the bench model. A stuck or early stabilization counter shows up as a ready flag outside its edge window, or as a gated clock edge before the limit is reached. That is caught within the limit plus about four register cycles. A pending bit that is dropped, kept too long or set at the wrong time shows up on irq and in IRQ rdata one cycle after the ready rise or the clear write.

// File: rtl/oscen_pkg.sv
package oscen_pkg;
   localparam int DATA_W   = 32;
   localparam int NSRC     = 2;
   localparam int SRC_EXT  = 0;
   localparam int SRC_INT  = 1;
   localparam int TRIM_W   = 5;
   localparam int CAL_W    = 8;
   localparam int TRIM_LSB = 8;
   localparam int CAL_LSB  = 16;
   localparam int BYP_BIT  = 4;
   localparam int PEND_LSB = 8;
   localparam int CLR_LSB  = 16;
   localparam logic [TRIM_W-1:0] TRIM_RST = 5'b10000;
   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_IRQ  = 1'b1;
endpackage

// File: rtl/oscen_sync2.sv
module oscen_sync2 (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic s1, s2;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s1 <= d;
         s2 <= s1;
      end
   end
   assign q = s2;
endmodule

// File: rtl/oscen_clkgate.sv
module oscen_clkgate #(
   parameter bit USE_LATCH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic gclk
);
   logic en_hold;
   generate
      if (USE_LATCH) begin : g_latch
         always_latch begin
            if (!rst_n)   en_hold = 1'b0;
            else if (!clk) en_hold = en;
         end
      end else begin : g_negflop
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_hold <= 1'b0;
            else        en_hold <= en;
         end
      end
   endgenerate
   assign gclk = clk & en_hold;
endmodule

// File: rtl/oscen_stab.sv
module oscen_stab #(
   parameter int  STAB_W    = 8,
   parameter bit  USE_LATCH = 1'b1,
   parameter bit  MAKE_DIV2 = 1'b0
) (
   input  logic              osc_clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic [STAB_W-1:0] limit,
   output logic              ready_src,
   output logic              gclk,
   output logic              div2
);
   logic              en_s;
   logic [STAB_W-1:0] cnt;
   logic              rdy_q;

   oscen_sync2 u_en_sync (.clk(osc_clk), .rst_n(rst_n), .d(en_req), .q(en_s));

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rdy_q <= 1'b0;
      end else if (!en_s) begin
         cnt   <= '0;
         rdy_q <= 1'b0;
      end else if (!rdy_q) begin
         if (cnt == limit - 1'b1) rdy_q <= 1'b1;
         cnt <= cnt + 1'b1;
      end
   end
   assign ready_src = rdy_q;

   oscen_clkgate #(.USE_LATCH(USE_LATCH)) u_gate (
      .clk(osc_clk), .rst_n(rst_n), .en(rdy_q), .gclk(gclk)
   );

   generate
      if (MAKE_DIV2) begin : g_div
         logic half;
         always_ff @(posedge osc_clk or negedge rst_n) begin
            if (!rst_n)      half <= 1'b0;
            else if (!rdy_q) half <= 1'b0;
            else             half <= ~half;
         end
         assign div2 = half;
      end else begin : g_nodiv
         assign div2 = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/oscen_regs.sv
module oscen_regs
   import oscen_pkg::*;
#(
   parameter logic [CAL_W-1:0] CAL_VAL    = 8'h5A,
   parameter bit               INT_ON_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NSRC-1:0]   rdy_sync,
   output logic [NSRC-1:0]   en_q,
   output logic [NSRC-1:0]   rdy_flag,
   output logic [NSRC-1:0]   pend_q,
   output logic              byp_q,
   output logic [TRIM_W-1:0] trim_q,
   output logic              irq
);
   logic [NSRC-1:0] ie_q;
   logic [NSRC-1:0] rdy_prev;
   logic [NSRC-1:0] en_rst;
   logic            wr_ctrl, wr_irq;

   assign wr_ctrl  = wr_en && (addr == ADDR_CTRL);
   assign wr_irq   = wr_en && (addr == ADDR_IRQ);
   assign rdy_flag = rdy_sync & en_q;

   always_comb begin
      en_rst          = '0;
      en_rst[SRC_INT] = INT_ON_RST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= en_rst;
         byp_q  <= 1'b0;
         trim_q <= TRIM_RST;
      end else if (wr_ctrl) begin
         for (int i = 0; i < NSRC; i++) en_q[i] <= wdata[2*i];
         if (!en_q[SRC_EXT]) byp_q <= wdata[BYP_BIT];
         trim_q <= wdata[TRIM_LSB +: TRIM_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q     <= '0;
         pend_q   <= '0;
         rdy_prev <= '0;
      end else begin
         rdy_prev <= rdy_flag;
         if (wr_irq) ie_q <= wdata[NSRC-1:0];
         for (int i = 0; i < NSRC; i++) begin
            if (rdy_flag[i] && !rdy_prev[i])          pend_q[i] <= 1'b1;
            else if (wr_irq && wdata[CLR_LSB + i])    pend_q[i] <= 1'b0;
         end
      end
   end

   assign irq = |(pend_q & ie_q);

   always_comb begin
      rdata = '0;
      if (addr == ADDR_CTRL) begin
         for (int i = 0; i < NSRC; i++) begin
            rdata[2*i]   = en_q[i];
            rdata[2*i+1] = rdy_flag[i];
         end
         rdata[BYP_BIT]                = byp_q;
         rdata[TRIM_LSB +: TRIM_W]     = trim_q;
         rdata[CAL_LSB +: CAL_W]       = CAL_VAL;
      end else begin
         rdata[NSRC-1:0]               = ie_q;
         rdata[PEND_LSB +: NSRC]       = pend_q;
      end
   end
endmodule

// File: rtl/oscen_ctrl.sv
module oscen_ctrl
   import oscen_pkg::*;
#(
   parameter int               STAB_W     = 8,
   parameter int               XTAL_STAB  = 48,
   parameter int               BYP_STAB   = 12,
   parameter int               INT_STAB   = 20,
   parameter logic [7:0]       CAL_VAL    = 8'h5A,
   parameter bit               INT_ON_RST = 1'b1,
   parameter bit               USE_LATCH  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq,
   input  logic        xtal_clk_i,
   input  logic        byp_clk_i,
   input  logic        int_osc_i,
   output logic        ext_clk_o,
   output logic        int_clk_o,
   output logic        int_div2_o,
   output logic        ext_ready_o,
   output logic        int_ready_o,
   output logic [4:0]  trim_o,
   output logic [7:0]  cal_o
);
   localparam int LIM_MAX = (1 << STAB_W) - 1;

   generate
      if (XTAL_STAB < 1 || XTAL_STAB > LIM_MAX) begin : g_bad_xtal
         $error("XTAL_STAB out of range for STAB_W");
      end
      if (BYP_STAB < 1 || BYP_STAB > LIM_MAX) begin : g_bad_byp
         $error("BYP_STAB out of range for STAB_W");
      end
      if (INT_STAB < 1 || INT_STAB > LIM_MAX) begin : g_bad_int
         $error("INT_STAB out of range for STAB_W");
      end
   endgenerate

   logic [NSRC-1:0]   src_en;
   logic [NSRC-1:0]   rdy_flag;
   logic [NSRC-1:0]   rdy_sync;
   logic [NSRC-1:0]   rdy_src;
   logic [NSRC-1:0]   pend_w;
   logic [NSRC-1:0]   osc_in;
   logic [NSRC-1:0]   gclk;
   logic [NSRC-1:0]   div_w;
   logic              byp_sel;
   logic [TRIM_W-1:0] trim_w;
   logic [STAB_W-1:0] lim [NSRC];

   assign osc_in[SRC_EXT] = byp_sel ? byp_clk_i : xtal_clk_i;
   assign osc_in[SRC_INT] = int_osc_i;
   assign lim[SRC_EXT]    = byp_sel ? STAB_W'(BYP_STAB) : STAB_W'(XTAL_STAB);
   assign lim[SRC_INT]    = STAB_W'(INT_STAB);

   oscen_regs #(.CAL_VAL(CAL_VAL), .INT_ON_RST(INT_ON_RST)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdy_sync(rdy_sync), .en_q(src_en), .rdy_flag(rdy_flag),
      .pend_q(pend_w), .byp_q(byp_sel), .trim_q(trim_w), .irq(irq)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      oscen_stab #(
         .STAB_W(STAB_W), .USE_LATCH(USE_LATCH), .MAKE_DIV2(i == SRC_INT)
      ) u_stab (
         .osc_clk(osc_in[i]), .rst_n(rst_n), .en_req(src_en[i]), .limit(lim[i]),
         .ready_src(rdy_src[i]), .gclk(gclk[i]), .div2(div_w[i])
      );
      oscen_sync2 u_rdy_sync (.clk(clk), .rst_n(rst_n), .d(rdy_src[i]), .q(rdy_sync[i]));
   end

   assign ext_clk_o   = gclk[SRC_EXT];
   assign int_clk_o   = gclk[SRC_INT];
   assign int_div2_o  = div_w[SRC_INT];
   assign ext_ready_o = rdy_flag[SRC_EXT];
   assign int_ready_o = rdy_flag[SRC_INT];
   assign trim_o      = trim_w;
   assign cal_o       = CAL_VAL;
endmodule

module oscen_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] src_en,
   input logic       byp_sel,
   input logic [1:0] pend_w,
   input logic       ext_ready_o,
   input logic       int_ready_o,
   input logic       irq
);
   assert_byp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en[0] && $past(src_en[0])) |-> $stable(byp_sel));

   assert_ext_rdy_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ready_o |-> src_en[0]);

   assert_int_rdy_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_ready_o |-> src_en[1]);

   assert_pend_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_w[0]) |-> ($past(ext_ready_o) && !$past(ext_ready_o, 2)));

   assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend_w != 2'b00));
endmodule

bind oscen_ctrl oscen_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .src_en(src_en), .byp_sel(byp_sel), .pend_w(pend_w),
   .ext_ready_o(ext_ready_o), .int_ready_o(int_ready_o), .irq(irq)
);

// File: tb/sim_oscen_ctrl.sv
`timescale 1ns/1ps
module sim_oscen_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int XS = 48, BS = 12, IS = 20;
   localparam logic [7:0] CALV = 8'h5A;

   logic clk = 0, rst_n = 0, wr_en = 0, addr = 0;
   logic [31:0] wdata = 0;
   logic [31:0] rdata;
   logic irq, xtal = 0, byp = 0, iosc = 0;
   logic ext_clk, int_clk, div2, ext_rdy, int_rdy;
   logic [4:0] trim;
   logic [7:0] cal;

   oscen_ctrl #(.XTAL_STAB(XS), .BYP_STAB(BS), .INT_STAB(IS), .CAL_VAL(CALV)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq(irq), .xtal_clk_i(xtal), .byp_clk_i(byp), .int_osc_i(iosc),
      .ext_clk_o(ext_clk), .int_clk_o(int_clk), .int_div2_o(div2),
      .ext_ready_o(ext_rdy), .int_ready_o(int_rdy), .trim_o(trim), .cal_o(cal)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   initial begin #1.3; forever #7.1  xtal = ~xtal; end
   initial begin #0.7; forever #3.05 byp  = ~byp;  end
   initial begin #1.9; forever #4.15 iosc = ~iosc; end

   int xt_tot = 0, bp_tot = 0, in_tot = 0, eg_cnt = 0, ig_cnt = 0, dv_cnt = 0;
   int early_ext = 0, early_int = 0;
   always @(posedge xtal) xt_tot++;
   always @(posedge byp)  bp_tot++;
   always @(posedge iosc) in_tot++;

   // reference model state
   logic       ext_en_m = 0, int_en_m = 1, byp_m = 0;
   logic [4:0] trim_m = 5'b10000;
   logic [1:0] ie_m = 0, pend_m = 0;
   int         xt_base = 0, bp_base = 0, in_base = 0;
   logic [1:0] obs_cur = 0, obs_prev = 0;

   function automatic int ext_since();
      return byp_m ? (bp_tot - bp_base) : (xt_tot - xt_base);
   endfunction
   function automatic int ext_lim();
      return byp_m ? BS : XS;
   endfunction
   function automatic int int_since();
      return in_tot - in_base;
   endfunction

   always @(posedge ext_clk) begin
      eg_cnt++;
      if (rst_n && ext_en_m && ext_since() < ext_lim()) early_ext++;
   end
   always @(posedge int_clk) begin
      ig_cnt++;
      if (rst_n && int_en_m && int_since() < IS) early_int++;
   end
   always @(posedge div2) dv_cnt++;

   always @(posedge clk) begin
      if (!rst_n) begin
         ext_en_m <= 0; int_en_m <= 1; byp_m <= 0; trim_m <= 5'b10000;
         ie_m <= 0; pend_m <= 0;
         xt_base <= xt_tot; bp_base <= bp_tot; in_base <= in_tot;
      end else begin
         for (int i = 0; i < 2; i++) begin
            logic clr;
            clr = wr_en && addr && wdata[16+i];
            pend_m[i] <= (obs_cur[i] && !obs_prev[i]) ? 1'b1 : (clr ? 1'b0 : pend_m[i]);
         end
         if (wr_en && !addr) begin
            if (!ext_en_m) byp_m <= wdata[4];
            if (wdata[0] && !ext_en_m) begin xt_base <= xt_tot; bp_base <= bp_tot; end
            if (wdata[2] && !int_en_m) in_base <= in_tot;
            ext_en_m <= wdata[0];
            int_en_m <= wdata[2];
            trim_m   <= wdata[12:8];
         end
         if (wr_en && addr) ie_m <= wdata[1:0];
      end
   end

   // per-cycle comparison
   int c_tot = 0, c_bad = 0;
   int eh [4] = '{0, 0, 0, 0};
   int ih [4] = '{0, 0, 0, 0};
   task automatic chk_c(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      c_tot++;
      if (!ok) begin
         c_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         logic [31:0] exp;
         exp = 0;
         if (!addr) begin
            exp[0] = ext_en_m; exp[1] = ext_rdy; exp[2] = int_en_m; exp[3] = int_rdy;
            exp[4] = byp_m; exp[12:8] = trim_m; exp[23:16] = CALV;
         end else begin
            exp[1:0] = ie_m; exp[9:8] = pend_m;
         end
         chk_c(rdata == exp, "R1/R2/R6/R7/R9 rdata", rdata, exp);
         chk_c(irq == |(pend_m & ie_m), "R10 irq", {31'd0, irq}, {31'd0, |(pend_m & ie_m)});
         chk_c(trim == trim_m, "R7 trim_o", {27'd0, trim}, {27'd0, trim_m});
         chk_c(cal == CALV, "R6 cal_o", {24'd0, cal}, {24'd0, CALV});
         if (!ext_en_m) chk_c(!ext_rdy, "R4 ext ready while disabled", {31'd0, ext_rdy}, 0);
         if (!int_en_m) chk_c(!int_rdy, "R4 int ready while disabled", {31'd0, int_rdy}, 0);
         if (ext_en_m && ext_since() < ext_lim())
            chk_c(!ext_rdy, "R3 ext ready early", {31'd0, ext_rdy}, 0);
         if (int_en_m && int_since() < IS)
            chk_c(!int_rdy, "R3 int ready early", {31'd0, int_rdy}, 0);
         if (ext_en_m && eh[3] >= ext_lim() + 3)
            chk_c(ext_rdy, "R3 ext ready late", {31'd0, ext_rdy}, 1);
         if (int_en_m && ih[3] >= IS + 3)
            chk_c(int_rdy, "R3 int ready late", {31'd0, int_rdy}, 1);
      end
      for (int k = 3; k > 0; k--) begin eh[k] = eh[k-1]; ih[k] = ih[k-1]; end
      eh[0] = (rst_n && ext_en_m) ? ext_since() : 0;
      ih[0] = (rst_n && int_en_m) ? int_since() : 0;
      obs_prev = obs_cur;
      obs_cur  = {int_rdy, ext_rdy};
   end

   // directed checks
   int m_tot = 0, m_bad = 0;
   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      m_tot++;
      if (!ok) begin
         m_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1;
      @(negedge clk);
      wr_en = 0; wdata = 0;
   endtask

   task automatic wait_flag(input bit ext, input int maxc, output int took);
      took = 0;
      while (!(ext ? ext_rdy : int_rdy) && took < maxc) begin
         @(negedge clk); #3; took++;
      end
   endtask

   localparam logic [31:0] TRIM7 = 32'h0000_0700;
   int took, a0, a1, b0, b1;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #3;
      // R1 reset state
      chk(rdata == {8'd0, CALV, 3'd0, 5'b10000, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
          "R1 CTRL reset", rdata, {8'd0, CALV, 3'd0, 5'b10000, 8'h04});
      addr = 1; #1;
      chk(rdata == 0, "R1 IRQ reset", rdata, 0);
      chk(irq == 0, "R1 irq reset", {31'd0, irq}, 0);
      addr = 0;
      // R3 internal source comes up
      wait_flag(0, 400, took);
      chk(int_rdy, "R3 int ready reached", {31'd0, int_rdy}, 1);
      // R8 divider ratio
      a0 = ig_cnt; b0 = dv_cnt;
      repeat (100) @(negedge clk);
      a1 = ig_cnt - a0; b1 = dv_cnt - b0;
      chk(a1 > 50, "R5 int gated clock toggles", a1, 51);
      chk((b1*2 >= a1 - 2) && (b1*2 <= a1 + 2), "R8 div2 ratio", b1*2, a1);
      // R9/R10: internal pending set, interrupt masked until enabled
      @(negedge clk); #3;
      chk(irq == 0, "R10 irq masked", {31'd0, irq}, 0);
      wr(1, 32'h2); #3;
      chk(irq == 1, "R10 irq with int enable", {31'd0, irq}, 1);
      wr(1, 32'h0002_0002); #3;
      chk(irq == 0, "R9 clear int pending", {31'd0, irq}, 0);
      // R7 trim, R6 calibration write ignored
      wr(0, TRIM7 | 32'h4); #3;
      chk(trim == 5'h07, "R7 trim written", {27'd0, trim}, 32'h7);
      wr(0, TRIM7 | 32'h4 | 32'h00FF_0000); #3;
      chk(cal == CALV && rdata[23:16] == CALV, "R6 cal write ignored", {24'd0, rdata[23:16]}, {24'd0, CALV});
      // external crystal
      wr(1, 32'h3);
      wr(0, TRIM7 | 32'h5);
      wait_flag(1, 400, took);
      chk(ext_rdy, "R3 ext crystal ready", {31'd0, ext_rdy}, 1);
      chk(took >= 60, "R3 crystal delay not short", took, 60);
      @(negedge clk); #3;
      chk(irq == 1, "R9 ext pending raises irq", {31'd0, irq}, 1);
      // R2 bypass write ignored while enabled
      wr(0, TRIM7 | 32'h15); #3;
      chk(rdata[4] == 0, "R2 bypass locked while enabled", {31'd0, rdata[4]}, 0);
      // R4 disable
      wr(0, TRIM7 | 32'h4); #3;
      chk(!ext_rdy, "R4 ready drops with enable", {31'd0, ext_rdy}, 0);
      repeat (10) @(negedge clk);
      a0 = eg_cnt;
      repeat (50) @(negedge clk);
      chk(eg_cnt == a0, "R5 ext gated clock quiet when off", eg_cnt - a0, 0);
      // clear ext pending
      wr(1, 32'h0001_0003); #3;
      chk(irq == 0, "R9 clear ext pending", {31'd0, irq}, 0);
      // R2 bypass mode
      wr(0, TRIM7 | 32'h14); #3;
      chk(rdata[4] == 1, "R2 bypass written while off", {31'd0, rdata[4]}, 1);
      wr(0, TRIM7 | 32'h15);
      wait_flag(1, 400, took);
      chk(ext_rdy && took <= 20, "R2 bypass uses short count", took, 20);
      a0 = eg_cnt;
      repeat (20) @(negedge clk);
      chk(eg_cnt - a0 > 20, "R5 bypass gated clock toggles", eg_cnt - a0, 21);
      @(negedge clk); #3;
      chk(irq == 1, "R9 pending set again after bypass ready", {31'd0, irq}, 1);
      chk(early_ext == 0, "R5 no early ext gated edge", early_ext, 0);
      chk(early_int == 0, "R5 no early int gated edge", early_int, 0);
      $display("test done: total=%0d bad=%0d", m_tot + c_tot, m_bad + c_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog expired t=%0t actual=hung expected=done", $time);
      $display("test done: total=%0d bad=%0d", m_tot + c_tot + 1, m_bad + c_bad + 1);
      $finish;
   end
endmodule